// File: doc/BRIEF.md
# Selectable Buffer/Register Address Fanout

This block takes one address word and drives four identical copies of it onto four separate output groups. Each group can be released to high impedance. It sits where a single address source has to reach four independent memory locations. A select pin chooses where the driven value comes from. In one setting the copies follow the address input directly, with no clock involved. In the other setting the copies show an internal edge-triggered register that captures the address on every rising clock edge.

Two active-low enables each gate a pair of output groups. A released group stops driving and floats. The register does not depend on the select pin or on the enables. It loads on every rising edge, so new data can be taken in, or old data kept, while the outputs are released. The register has no reset, and its contents are undefined until the first rising edge. The interface is plain control and data pins with no handshake, because the block is a combinational or registered fanout with no flow to stall.

Top module: `addr_fanout_driver`

## Requirements
- R1: With `path_sel` = 1 (buffer path), every enabled group equals `addr_in` in the same cycle, with no clock edge needed.
- R2: With `path_sel` = 0 (register path), every enabled group shows the value `addr_in` had at the most recent rising `clk` edge. Changes to `addr_in` between edges do not reach the outputs.
- R3: All four groups carry the same value whenever they are enabled.
- R4: `oe_n[0]` gates groups 0 and 1, and `oe_n[1]` gates groups 2 and 3. A low bit drives the groups. A high bit releases them to high impedance.
- R5: The enables behave identically on the buffer path and the register path.
- R6: The register loads `addr_in` on every rising edge, whatever the values of `path_sel` and `oe_n`. A value loaded while the groups are released appears as soon as the groups are re-enabled, with no further edge.
- R7: A change of `path_sel` changes the driven source in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| path_sel | input | 1 | 1 = buffer path, 0 = register path |
| oe_n | input | 2 | Active-low enables: bit 0 for groups 0-1, bit 1 for groups 2-3 |
| addr_in | input | 9 | Address input |
| grp0_out | output | 9 | Output group 0, tri-state |
| grp1_out | output | 9 | Output group 1, tri-state |
| grp2_out | output | 9 | Output group 2, tri-state |
| grp3_out | output | 9 | Output group 3, tri-state |

## Verification
A wrong register value appears on every enabled group in the cycle after the bad capture, but only while the register path is selected. That means a capture fault can stay hidden behind the buffer path or behind released groups until the block switches back. The bench therefore loads data while the groups are released and while the buffer path is selected, then exposes the register without an edge in between. A miswired enable shows at once as a driven group that should float, or as a floating group that should drive. A pull-up on each output separates these two cases when the input is driven low.

// File: rtl/addr_fan_pkg.sv
package addr_fan_pkg;
  localparam int unsigned GRP_CNT    = 4;
  localparam int unsigned GRP_PER_OE = 2;
  localparam int unsigned OE_CNT     = GRP_CNT / GRP_PER_OE;

  typedef enum logic {
    PATH_REG = 1'b0,
    PATH_BUF = 1'b1
  } path_e;
endpackage

// File: rtl/afd_capture_reg.sv
module afd_capture_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Free-running capture: no reset, no enable, loads every rising edge.
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/afd_path_select.sv
module afd_path_select
  import addr_fan_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  path_e        sel,
  input  logic [W-1:0] buf_d,
  input  logic [W-1:0] reg_q,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      PATH_BUF: y = buf_d;
      default:  y = reg_q;
    endcase
  end
endmodule

// File: rtl/afd_enable_decode.sv
module afd_enable_decode
  import addr_fan_pkg::*;
(
  input  logic [OE_CNT-1:0]  oe_n,
  output logic [GRP_CNT-1:0] drv_en
);
  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    assign drv_en[g] = ~oe_n[g / GRP_PER_OE];
  end
endmodule

// File: rtl/addr_fanout_driver.sv
module addr_fanout_driver
  import addr_fan_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              path_sel,
  input  logic [OE_CNT-1:0] oe_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] grp0_out,
  output logic [ADDR_W-1:0] grp1_out,
  output logic [ADDR_W-1:0] grp2_out,
  output logic [ADDR_W-1:0] grp3_out
);
  logic [ADDR_W-1:0]  core_q;
  logic [ADDR_W-1:0]  path_y;
  logic [GRP_CNT-1:0] drv_en;
  path_e              sel_e;

  assign sel_e = path_e'(path_sel);

  afd_capture_reg #(.W(ADDR_W)) u_reg (
    .clk (clk),
    .d   (addr_in),
    .q   (core_q)
  );

  afd_path_select #(.W(ADDR_W)) u_sel (
    .sel   (sel_e),
    .buf_d (addr_in),
    .reg_q (core_q),
    .y     (path_y)
  );

  afd_enable_decode u_oe (
    .oe_n   (oe_n),
    .drv_en (drv_en)
  );

  assign grp0_out = drv_en[0] ? path_y : 'z;
  assign grp1_out = drv_en[1] ? path_y : 'z;
  assign grp2_out = drv_en[2] ? path_y : 'z;
  assign grp3_out = drv_en[3] ? path_y : 'z;
endmodule

// File: rtl/addr_fanout_driver_chk.sv
module addr_fanout_driver_chk
  import addr_fan_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input logic               clk,
  input logic               path_sel,
  input logic [OE_CNT-1:0]  oe_n,
  input logic [W-1:0]       addr_in,
  input logic [W-1:0]       reg_q,
  input logic [W-1:0]       path_y,
  input logic [GRP_CNT-1:0] drv_en
);
  // No reset exists; checks start once one edge has loaded the register.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_BUF_FOLLOW: assert property (@(posedge clk) disable iff (!armed)
    path_sel |-> path_y == addr_in);                                  // R1
  AST_REG_SOURCE: assert property (@(posedge clk) disable iff (!armed)
    !path_sel |-> path_y == reg_q);                                   // R2
  AST_REG_LOADS: assert property (@(posedge clk) disable iff (!armed)
    reg_q == $past(addr_in));                                         // R6
  AST_OE_LOW_PAIR: assert property (@(posedge clk) disable iff (!armed)
    drv_en[1:0] == {2{~oe_n[0]}});                                    // R4
  AST_OE_HIGH_PAIR: assert property (@(posedge clk) disable iff (!armed)
    drv_en[3:2] == {2{~oe_n[1]}});                                    // R4
endmodule

bind addr_fanout_driver addr_fanout_driver_chk #(.W(ADDR_W)) u_chk (
  .clk      (clk),
  .path_sel (path_sel),
  .oe_n     (oe_n),
  .addr_in  (addr_in),
  .reg_q    (core_q),
  .path_y   (path_y),
  .drv_en   (drv_en)
);

// File: tb/addr_fanout_driver_tb.sv
module addr_fanout_driver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam logic [W-1:0] FLOAT = '1;  // pull-up value of a released group

  logic         clk = 1'b0;
  logic         path_sel = 1'b1;
  logic [1:0]   oe_n = 2'b11;
  logic [W-1:0] addr_in = '0;
  tri1  [W-1:0] g0, g1, g2, g3;
  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] model_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_fanout_driver #(.ADDR_W(W)) u_dut (
    .clk(clk), .path_sel(path_sel), .oe_n(oe_n), .addr_in(addr_in),
    .grp0_out(g0), .grp1_out(g1), .grp2_out(g2), .grp3_out(g3)
  );

  // Reference register, built from R2/R6.
  always @(posedge clk) model_q <= addr_in;

  function automatic logic [W-1:0] grp_val(int g);
    case (g)
      0: return g0;
      1: return g1;
      2: return g2;
      default: return g3;
    endcase
  endfunction

  task automatic chk(string req, int g, logic [W-1:0] exp);
    logic [W-1:0] act = grp_val(g);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s group %0d actual %h expected %h", req, g, act, exp);
    end
  endtask

  // Checks all groups against the model, given the current mode and enables.
  task automatic chk_all(string req, logic [W-1:0] src);
    for (int g = 0; g < 4; g++)
      chk(req, g, oe_n[g/2] ? FLOAT : src);
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  task automatic t_released_state();
    oe_n = 2'b11; addr_in = '0; path_sel = 1'b1; #1;
    chk_all("R4", '0);                       // both pairs float
  endtask

  task automatic t_buffer();
    path_sel = 1'b1; oe_n = 2'b00;
    addr_in = 9'h0A5; #1; chk_all("R1", 9'h0A5);
    addr_in = 9'h000; #1; chk_all("R3", 9'h000);
    @(negedge clk); addr_in = 9'h13C; #1; chk_all("R1", 9'h13C);
  endtask

  task automatic t_register();
    path_sel = 1'b0; oe_n = 2'b00;
    @(negedge clk); addr_in = 9'h055;
    edge_step(); chk_all("R2", 9'h055);
    addr_in = 9'h0F0; #1; chk_all("R2", 9'h055);   // mid-cycle change hidden
    edge_step(); chk_all("R2", 9'h0F0);
    chk_all("R2", model_q);
  endtask

  task automatic t_enables();
    addr_in = 9'h000;
    for (int m = 0; m < 2; m++) begin
      path_sel = m[0];
      edge_step();
      for (int e = 0; e < 4; e++) begin
        oe_n = e[1:0]; #1;
        chk_all(m == 0 ? "R5" : "R4", 9'h000);
      end
    end
  endtask

  task automatic t_hold_while_released();
    path_sel = 1'b0; oe_n = 2'b11;
    @(negedge clk); addr_in = 9'h0C3; edge_step();
    @(negedge clk); addr_in = 9'h000;               // no further edge yet
    oe_n = 2'b00; #1; chk_all("R6", 9'h0C3);
    oe_n = 2'b11; edge_step();                      // loads 000 while floating
    @(negedge clk); oe_n = 2'b00; #1; chk_all("R6", 9'h000);
    path_sel = 1'b1; addr_in = 9'h0AA; edge_step(); // loads under buffer path
    @(negedge clk); addr_in = 9'h011; path_sel = 1'b0; #1;
    chk_all("R6", 9'h0AA);
  endtask

  task automatic t_mode_switch();
    oe_n = 2'b00;
    @(negedge clk); addr_in = 9'h066; edge_step();
    @(negedge clk); addr_in = 9'h099; path_sel = 1'b0; #1;
    chk_all("R7", 9'h066);
    path_sel = 1'b1; #1; chk_all("R7", 9'h099);
    path_sel = 1'b0; #1; chk_all("R7", 9'h066);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    t_released_state();
    t_buffer();
    t_register();
    t_enables();
    t_hold_while_released();
    t_mode_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule